// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical page number by walking a hashed page table kept in ordinary memory. The top four address bits pick one of sixteen segment descriptors. The descriptor supplies a 24-bit segment identifier, and the address supplies a 16-bit page index. From these two values the walker forms a hash and reads the entries of one 64-byte group. If that search fails, it reads a second group found through the complemented hash.

A client places one request on a valid/ready handshake and receives a one-cycle result pulse. The pulse carries a result code, the page number, and the read and write rights granted. The segment descriptors and the table base arrive as plain inputs that must stay stable while a walk is running. Memory is reached through a single-word port, where a request is held until it is acknowledged. On a successful hit, the walker updates the entry's referenced and changed flags in place.

Top module: `hpt_walker`

## Requirements
- R1: The descriptor is taken from `seg_file[32*k +: 32]`, where k = address bits 31:28. Descriptor bits 23:0 form the segment ID and address bits 27:12 form the page index. An entry's first word matches only when its bits 30:7 equal the segment ID and its bits 5:0 equal page-index bits 15:10.
- R2: The primary group address is (table_base & 0xFFFF0000) | (H1 & M). Here H1 = ((segID ^ pageidx) & 0x7FFFF) << 6 and M = (table_base[8:0] << 16) | 0xFFC0. Slot s has its first word at group + 8s and its second word at group + 8s + 4. The first memory read of a walk is slot 0 of the primary group.
- R3: The secondary group uses H2 = ~H1 & 0x01FFFFC0 in place of H1. It is read only after the primary search has failed. First-word bit 6 must be 0 for a primary match and 1 for a secondary match.
- R4: An entry counts only if first-word bit 31 is set. Slots are examined in order 0 to 7, and the first matching slot decides the result for its group.
- R5: The protection key is 1 when descriptor bit 29 is set and `req_user` = 1, or when descriptor bit 30 is set and `req_user` = 0. In every other case the key is 0.
- R6: PP is second-word bits 1:0. With key 0, reads are always allowed and writes are allowed unless PP = 3. With key 1, PP = 0 allows nothing, PP = 1 or 3 allows reads only, and PP = 2 allows reads and writes.
- R7: A matching entry that refuses the access yields code 2 (protection fault), with `resp_rd`/`resp_wr` at 0 and no memory write. If the primary search ends in a protection fault and the secondary search finds nothing, the result is still code 2. A secondary hit that allows the access gives code 0.
- R8: On success the second word is written back with bit 8 (referenced) set. Bit 7 (changed) is also set when the access is a write. The write happens only if the word actually changes.
- R9: On success `resp_rd`/`resp_wr` report the rights of R6. Write permission is withheld when the changed bit is still clear after the access.
- R10: A descriptor with bit 31 set yields code 4 (direct-store) at once, without any memory access.
- R11: An instruction fetch (`req_fetch` = 1) through a descriptor with bit 28 set yields code 3 (no-execute) without any memory access.
- R12: `req_ready` is high only while idle, and a request is taken when `req_valid` and `req_ready` are both high. `resp_valid` is a one-cycle pulse. A success reports code 0 and sets `resp_page` to second-word bits 31:12.
- R13: When neither group holds a matching entry, the result is code 1 (not found), after 8 primary and 8 secondary first-word reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Requester in user state |
| seg_file | input | 512 | Sixteen 32-bit segment descriptors, descriptor k at bits 32k+31:32k |
| table_base | input | 32 | Page table base and size mask |
| resp_valid | output | 1 | Result pulse |
| resp_code | output | 3 | 0 ok, 1 not found, 2 protection, 3 no-execute, 4 direct-store |
| resp_page | output | 20 | Physical page number on success |
| resp_rd | output | 1 | Read right granted |
| resp_wr | output | 1 | Write right granted |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The assertions check several properties on every cycle. Every write-back targets a second word and carries the referenced bit. The memory port is quiet while the walker is idle. The result pulse lasts one cycle. Faults never grant rights, and direct-store results return straight from idle.

Some behaviour only the directed scenarios can show, because each needs a table prepared in memory and a known expected result. This covers the hash and mask arithmetic of both groups, slot order, and the valid and hash-select filters. It also covers the full key and PP rights table, the rule that a primary protection fault outlives a secondary miss, and the exact flag values written back.

// File: rtl/hpt_walker.sv
module hpt_walker (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [31:0]  req_addr,
  input  logic         req_write,
  input  logic         req_fetch,
  input  logic         req_user,
  input  logic [511:0] seg_file,
  input  logic [31:0]  table_base,
  output logic         resp_valid,
  output logic [2:0]   resp_code,
  output logic [19:0]  resp_page,
  output logic         resp_rd,
  output logic         resp_wr,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic         mem_ack,
  input  logic [31:0]  mem_rdata
);
  localparam logic [2:0] RC_OK = 3'd0, RC_MISS = 3'd1, RC_PROT = 3'd2,
                         RC_NOEXEC = 3'd3, RC_DIRECT = 3'd4;
  localparam logic [2:0] LAST_SLOT = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_W0, S_W1, S_UPD, S_DONE} st_t;
  st_t st;

  logic [23:0] vsid;
  logic [15:0] pidx;
  logic        wr_r, key_r, sec, prot_seen;
  logic [2:0]  slot, code;
  logic [31:0] w1;
  logic        perm_rd, perm_wr;

  logic [31:0] seg_in;
  assign seg_in = seg_file[{req_addr[31:28], 5'b0} +: 32];

  logic [31:0] h1, h2, mask, grp, ptem, upd;
  logic        tag_hit, can_rd, can_wr, allowed, need_wb;
  logic [1:0]  pp;

  assign h1   = {7'b0, vsid[18:0] ^ {3'b0, pidx}, 6'b0};
  assign h2   = ~h1 & 32'h01FF_FFC0;
  assign mask = {7'b0, table_base[8:0], 16'hFFC0};
  assign grp  = {table_base[31:16], 16'b0} | ((sec ? h2 : h1) & mask);
  assign ptem = {1'b0, vsid, 1'b0, pidx[15:10]};

  assign tag_hit = mem_rdata[31] && (mem_rdata[6] == sec)
                   && ((mem_rdata & 32'h7FFF_FFBF) == ptem);
  assign pp      = mem_rdata[1:0];
  assign can_rd  = !key_r || (pp != 2'd0);
  assign can_wr  = key_r ? (pp == 2'd2) : (pp != 2'd3);
  assign allowed = wr_r ? can_wr : can_rd;

  assign upd     = w1 | 32'h0000_0100 | (wr_r ? 32'h0000_0080 : 32'h0);
  assign need_wb = (upd != w1);

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_DONE);
  assign resp_code  = code;
  assign resp_page  = (code == RC_OK) ? w1[31:12] : 20'd0;
  assign resp_rd    = perm_rd;
  assign resp_wr    = perm_wr;

  assign mem_req   = (st == S_W0) || (st == S_W1) || ((st == S_UPD) && need_wb);
  assign mem_we    = (st == S_UPD);
  assign mem_addr  = grp | {26'b0, slot, (st == S_W0) ? 3'b000 : 3'b100};
  assign mem_wdata = upd;

  logic unused_ok;
  assign unused_ok = ^{table_base[15:9], req_addr[11:0], seg_in[27:24]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; vsid <= '0; pidx <= '0; wr_r <= 1'b0; key_r <= 1'b0;
      sec <= 1'b0; prot_seen <= 1'b0; slot <= '0; code <= RC_OK;
      w1 <= '0; perm_rd <= 1'b0; perm_wr <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          vsid <= seg_in[23:0];
          pidx <= req_addr[27:12];
          wr_r <= req_write;
          key_r <= (seg_in[29] && req_user) || (seg_in[30] && !req_user);
          sec <= 1'b0; slot <= '0; prot_seen <= 1'b0;
          w1 <= '0; perm_rd <= 1'b0; perm_wr <= 1'b0;
          if (seg_in[31]) begin
            code <= RC_DIRECT; st <= S_DONE;
          end else if (req_fetch && seg_in[28]) begin
            code <= RC_NOEXEC; st <= S_DONE;
          end else begin
            st <= S_W0;
          end
        end
        S_W0: if (mem_ack) begin
          if (tag_hit) st <= S_W1;
          else if (slot != LAST_SLOT) slot <= slot + 3'd1;
          else if (!sec) begin
            sec <= 1'b1; slot <= '0;
          end else begin
            code <= prot_seen ? RC_PROT : RC_MISS; st <= S_DONE;
          end
        end
        S_W1: if (mem_ack) begin
          if (allowed) begin
            w1 <= mem_rdata; perm_rd <= can_rd; perm_wr <= can_wr; st <= S_UPD;
          end else begin
            prot_seen <= 1'b1;
            if (!sec) begin
              sec <= 1'b1; slot <= '0; st <= S_W0;
            end else begin
              code <= RC_PROT; st <= S_DONE;
            end
          end
        end
        S_UPD: if (!need_wb || mem_ack) begin
          w1 <= upd; code <= RC_OK; perm_wr <= perm_wr && upd[7]; st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_wb_sets_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[8]);
  assert_wb_second_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[2:0] == 3'b100));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
  assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_fault_no_rights_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code != RC_OK) |-> (!resp_rd && !resp_wr));
  assert_direct_immediate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code == RC_DIRECT) |-> $past(req_ready));
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_addr = '0, table_base = '0;
  logic [511:0] seg_file = '0;
  logic req_ready, resp_valid, resp_rd, resp_wr, mem_req, mem_we, mem_ack;
  logic [2:0] resp_code;
  logic [19:0] resp_page;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  hpt_walker u0 (.clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_write,
    .req_fetch, .req_user, .seg_file, .table_base, .resp_valid, .resp_code,
    .resp_page, .resp_rd, .resp_wr, .mem_req, .mem_we, .mem_addr, .mem_wdata,
    .mem_ack, .mem_rdata);

  logic [31:0] mem [1024];
  logic [31:0] rlog [40];
  int nrd, nwr, checks = 0, fails = 0;
  logic [2:0] rc; logic [19:0] rp; logic rrd, rwr;

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) if (mem_req && mem_ack) begin
    if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; nwr++; end
    else begin if (nrd < 40) rlog[nrd] = mem_addr; nrd++; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_of(logic [31:0] s, logic [31:0] a, logic [31:0] tb, bit sec);
    logic [31:0] h, m;
    h = (((s & 32'hFF_FFFF) ^ ((a >> 12) & 32'hFFFF)) & 32'h7FFFF) << 6;
    if (sec) h = ~h & 32'h01FF_FFC0;
    m = ((tb & 32'h1FF) << 16) | 32'hFFC0;
    return (tb & 32'hFFFF_0000) | (h & m);
  endfunction

  function automatic logic [31:0] pte0(logic [31:0] s, logic [31:0] a, bit sec);
    return 32'h8000_0000 | ((s & 32'hFF_FFFF) << 7) | (32'(sec) << 6) | ((a >> 22) & 32'h3F);
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic put(input logic [31:0] g, input int s, input logic [31:0] w0, input logic [31:0] w1);
    mem[((g + 32'(s * 8)) >> 2) & 1023] = w0;
    mem[((g + 32'(s * 8 + 4)) >> 2) & 1023] = w1;
  endtask

  function automatic logic [31:0] peek1(logic [31:0] g, int s);
    return mem[((g + 32'(s * 8 + 4)) >> 2) & 1023];
  endfunction

  task automatic set_seg(input int k, input logic [31:0] v);
    seg_file[k*32 +: 32] = v;
  endtask

  task automatic run(input logic [31:0] a, input bit w, input bit f, input bit u);
    int n;
    nrd = 0; nwr = 0;
    @(negedge clk);
    req_addr = a; req_write = w; req_fetch = f; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
    check("R12 response arrives", 32'(resp_valid), 32'd1);
    rc = resp_code; rp = resp_page; rrd = resp_rd; rwr = resp_wr;
    @(negedge clk);
    check("R12 single-cycle pulse", 32'(resp_valid), 32'd0);
  endtask

  localparam logic [31:0] SA = 32'h0000_1234, VA = 32'h1056_7ABC;

  task automatic t_reset();
    check("R12 reset ready", 32'(req_ready), 32'd1);
    check("R12 reset no resp", 32'(resp_valid), 32'd0);
    check("R12 reset no mem", 32'(mem_req), 32'd0);
  endtask

  task automatic prep_primary(input logic [31:0] w1);
    logic [31:0] g;
    clear_mem(); table_base = 32'h0; set_seg(1, SA);
    g = grp_of(SA, VA, 0, 0);
    put(g, 0, pte0(SA, VA, 0) & 32'h7FFF_FFFF, 32'hAAAAA_002);
    put(g, 1, pte0(SA, VA, 1), 32'hBBBBB_002);
    put(g, 2, pte0(SA + 1, VA, 0), 32'hCCCCC_002);
    put(g, 3, pte0(SA, VA, 0), w1);
  endtask

  task automatic t_primary_read();
    logic [31:0] g;
    prep_primary(32'h12345_002);
    g = grp_of(SA, VA, 0, 0);
    run(VA, 0, 0, 0);
    check("R1 R4 code ok", 32'(rc), 32'd0);
    check("R12 page", 32'(rp), 32'h12345);
    check("R2 first read addr", rlog[0], g);
    check("R9 read right", 32'(rrd), 32'd1);
    check("R9 write withheld C clear", 32'(rwr), 32'd0);
    check("R8 ref set", peek1(g, 3), 32'h12345_102);
    check("R8 one write", 32'(nwr), 32'd1);
  endtask

  task automatic t_write_changed();
    logic [31:0] g;
    prep_primary(32'h12345_000);
    g = grp_of(SA, VA, 0, 0);
    run(VA, 1, 0, 0);
    check("R8 write ok", 32'(rc), 32'd0);
    check("R9 write right", 32'(rwr), 32'd1);
    check("R8 ref+chg set", peek1(g, 3), 32'h12345_180);
  endtask

  task automatic t_flags_set();
    logic [31:0] g;
    prep_primary(32'h12345_182);
    g = grp_of(SA, VA, 0, 0);
    run(VA, 0, 0, 0);
    check("R8 no write when unchanged", 32'(nwr), 32'd0);
    check("R9 write right with C set", 32'(rwr), 32'd1);
    check("R8 word kept", peek1(g, 3), 32'h12345_182);
  endtask

  task automatic t_secondary();
    logic [31:0] s, a, tb, g1, g2;
    clear_mem(); s = 32'h00AB_CDEF; a = 32'h2FED_C000; tb = 32'h0012_0007;
    table_base = tb; set_seg(2, s);
    g1 = grp_of(s, a, tb, 0); g2 = grp_of(s, a, tb, 1);
    put(g2, 5, pte0(s, a, 1), 32'h54321_000);
    run(a, 0, 0, 0);
    check("R3 secondary hit", 32'(rc), 32'd0);
    check("R3 page", 32'(rp), 32'h54321);
    check("R2 primary addr with mask", rlog[0], g1);
    check("R3 secondary addr", rlog[8], g2);
  endtask

  task automatic t_notfound();
    clear_mem(); table_base = 0; set_seg(1, SA);
    run(VA, 0, 0, 0);
    check("R13 code", 32'(rc), 32'd1);
    check("R13 reads", 32'(nrd), 32'd16);
  endtask

  task automatic t_prot();
    logic [31:0] s, a, g1, g2;
    clear_mem(); table_base = 0; s = 32'h2000_0055; a = 32'h3000_1000;
    set_seg(3, s);
    g1 = grp_of(s, a, 0, 0); g2 = grp_of(s, a, 0, 1);
    put(g1, 0, pte0(s, a, 0), 32'h11111_000);
    run(a, 0, 0, 1);
    check("R7 prot over miss", 32'(rc), 32'd2);
    check("R7 no rights", 32'({rrd, rwr}), 32'd0);
    check("R7 no write", 32'(nwr), 32'd0);
    check("R7 word untouched", peek1(g1, 0), 32'h11111_000);
    put(g2, 2, pte0(s, a, 1), 32'h22222_001);
    run(a, 0, 0, 1);
    check("R7 secondary after prot", 32'(rc), 32'd0);
    check("R7 page", 32'(rp), 32'h22222);
    check("R6 key1 pp1 rights", 32'({rrd, rwr}), 32'b10);
  endtask

  task automatic t_rights();
    logic [31:0] s, a, g;
    a = 32'h6123_4000;
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        for (int w = 0; w < 2; w++) begin
          bit u, key, erd, ewr, ok;
          s = (m == 0 || m == 3) ? 32'h2000_0321 : 32'h4000_0321;
          u = (m == 1 || m == 3);
          key = (m >= 2);
          erd = !key || (p != 0);
          ewr = key ? (p == 2) : (p != 3);
          ok = w ? ewr : erd;
          clear_mem(); table_base = 0; set_seg(6, s);
          g = grp_of(s, a, 0, 0);
          put(g, 4, pte0(s, a, 0), 32'h0ABCD_180 | 32'(p));
          run(a, w[0], 0, u);
          check($sformatf("R5 R6 code m%0d pp%0d w%0d", m, p, w), 32'(rc), ok ? 32'd0 : 32'd2);
          check($sformatf("R6 rights m%0d pp%0d w%0d", m, p, w), 32'({rrd, rwr}),
                ok ? 32'({erd, ewr}) : 32'd0);
        end
  endtask

  task automatic t_direct_noexec();
    logic [31:0] s, a, g;
    clear_mem(); table_base = 0;
    set_seg(4, 32'h8000_0001);
    run(32'h4000_0000, 0, 0, 0);
    check("R10 direct code", 32'(rc), 32'd4);
    check("R10 no memory", 32'(nrd + nwr), 32'd0);
    s = 32'h1000_0777; a = 32'h5000_3000; set_seg(5, s);
    g = grp_of(s, a, 0, 0);
    put(g, 0, pte0(s, a, 0), 32'h33333_180);
    run(a, 0, 1, 0);
    check("R11 noexec code", 32'(rc), 32'd3);
    check("R11 no memory", 32'(nrd), 32'd0);
    run(a, 0, 0, 0);
    check("R11 data access allowed", 32'(rc), 32'd0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_primary_read();
    t_write_changed();
    t_flags_set();
    t_secondary();
    t_notfound();
    t_prot();
    t_rights();
    t_direct_noexec();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule